// File: doc/BRIEF.md
# Dual Calendar Alarm Matcher

This block watches a running calendar (second, minute, hour, day of month, month and day of week) and compares it against two alarm slots that are fully independent. Each slot holds one target value for every calendar field, plus a separate match-enable bit for each field. A slot fires when every field that is enabled equals the current time. Enabling only the seconds field makes the slot fire once a minute. Enabling only the weekday field makes it fire on that weekday. Enabling every field pins it to one exact moment.

Comparison happens only in cycles where the time source pulses `tick`, which marks a new seconds value on the time inputs. Each slot owns a small flag state machine with two states. `FLG_IDLE` moves to `FLG_SET` when the slot matches (transition *arm-hit*). `FLG_SET` moves back to `FLG_IDLE` only when software pulses that slot's clear strobe and no match arrives in the same cycle (transition *clear*). Every other case holds the current state (transition *hold*). Software can poll the flags directly. It can also route either flag onto a shared active-low interrupt line through a per-slot interrupt enable.

The alarm values are written one field at a time through a narrow write port. A match is still detected and flagged while software is accessing the block.

Top module: `alarm_pair_matcher`

## Requirements
- R1: While `rst_n` is low and after reset, both flags read 0 and `irq_n` reads 1. Every stored field value is 0 and every field-match enable is off.
- R2: A cycle with `wr_en` high writes to slot `wr_idx`. The field is selected by `wr_field`: 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 weekday. The low bits of `wr_data` (field width: 6, 6, 5, 5, 4, 3) become the field value and `wr_match_en` becomes that field's enable. Codes 6 and 7 change nothing.
- R3: In a cycle with `tick` high, a slot matches when it has at least one enabled field and every enabled field equals the current time. A match sets that slot's flag at the next clock edge.
- R4: Without `tick`, no flag becomes set, whatever the time inputs carry.
- R5: A field whose enable is off does not take part in the comparison. A slot with no enabled field never matches.
- R6: A set flag stays set until its `clr` bit is pulsed, and then it reads 0 after the next edge. When a match and a clear for the same slot arrive in one cycle, the flag ends up set.
- R7: `irq_n` is low exactly when some slot has its flag set and its `irq_en` bit high. It follows flag and enable changes in the same cycle. A flag still sets and reads back when its `irq_en` bit is off.
- R8: A write, match or clear for one slot leaves the other slot's values, enables and flag unchanged.
- R9: When a write and a `tick` fall in the same cycle, the comparison uses the slot contents from before the write. The new value applies from the next tick on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe: time inputs carry a new seconds value |
| cur_sec | input | 6 | Current second |
| cur_min | input | 6 | Current minute |
| cur_hour | input | 5 | Current hour |
| cur_day | input | 5 | Current day of month |
| cur_mon | input | 4 | Current month |
| cur_wday | input | 3 | Current day of week |
| wr_en | input | 1 | Alarm field write strobe |
| wr_idx | input | 1 | Slot selected for the write |
| wr_field | input | 3 | Field code of the write |
| wr_data | input | 6 | Field value (low bits used) |
| wr_match_en | input | 1 | Match enable stored with the field |
| irq_en | input | 2 | Per-slot interrupt routing enable |
| clr | input | 2 | Per-slot flag clear strobe |
| flag | output | 2 | Sticky per-slot alarm flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A match or clear presented in a tick cycle shows on `flag` one clock edge later. `irq_n` is combinational from the flags and `irq_en`, so it is valid in the same cycle the flag or the enable changes. Stored writes take effect for the first tick after the write edge. The bench drives every input on the falling edge. It updates its own model at the rising edge from the inputs it drove and the model state from before that edge. It then compares `flag` and `irq_n` at the following falling edge, which is exactly one register stage after the stimulus.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int SEC_W      = 6;
    localparam int MIN_W      = 6;
    localparam int HOUR_W     = 5;
    localparam int DAY_W      = 5;
    localparam int MON_W      = 4;
    localparam int WDAY_W     = 3;
    localparam int NUM_FIELDS = 6;
    localparam int FCODE_W    = 3;
    localparam int DATA_W     = 6;

    typedef enum logic [FCODE_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DAY  = 3'd3,
        FLD_MON  = 3'd4,
        FLD_WDAY = 3'd5
    } field_code_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [DAY_W-1:0]  day;
        logic [MON_W-1:0]  mon;
        logic [WDAY_W-1:0] wday;
    } cal_t;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_SET  = 1'b1
    } flag_state_e;
endpackage

// File: rtl/alarm_slot_regs.sv
module alarm_slot_regs
    import alarm_pkg::*;
#(
    parameter int SLOT  = 0,
    parameter int IDX_W = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [FCODE_W-1:0]    wr_field,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  wr_match_en,
    output cal_t                  alm,
    output logic [NUM_FIELDS-1:0] fen
);
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(SLOT));

    // R2: one field per write; unused codes fall through to default
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm <= '0;
            fen <= '0;
        end else if (sel) begin
            case (field_code_e'(wr_field))
                FLD_SEC: begin
                    alm.sec <= wr_data[SEC_W-1:0];
                    fen[0]  <= wr_match_en;
                end
                FLD_MIN: begin
                    alm.min <= wr_data[MIN_W-1:0];
                    fen[1]  <= wr_match_en;
                end
                FLD_HOUR: begin
                    alm.hour <= wr_data[HOUR_W-1:0];
                    fen[2]   <= wr_match_en;
                end
                FLD_DAY: begin
                    alm.day <= wr_data[DAY_W-1:0];
                    fen[3]  <= wr_match_en;
                end
                FLD_MON: begin
                    alm.mon <= wr_data[MON_W-1:0];
                    fen[4]  <= wr_match_en;
                end
                FLD_WDAY: begin
                    alm.wday <= wr_data[WDAY_W-1:0];
                    fen[5]   <= wr_match_en;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
(
    input  logic                  tick,
    input  cal_t                  now,
    input  cal_t                  alm,
    input  logic [NUM_FIELDS-1:0] fen,
    output logic                  hit
);
    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] ok;

    assign eq[0] = (now.sec  == alm.sec);
    assign eq[1] = (now.min  == alm.min);
    assign eq[2] = (now.hour == alm.hour);
    assign eq[3] = (now.day  == alm.day);
    assign eq[4] = (now.mon  == alm.mon);
    assign eq[5] = (now.wday == alm.wday);

    // R5: a disabled field counts as satisfied
    assign ok  = eq | ~fen;
    // R3, R4, R5: needs a tick and at least one enabled field
    assign hit = tick && (|fen) && (&ok);
endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    flag_state_e st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FLG_IDLE;
        else        st <= st_nxt;
    end

    // R6: a match beats a clear in the same cycle
    always_comb begin
        st_nxt = st;
        unique case (st)
            FLG_IDLE: if (hit)         st_nxt = FLG_SET;
            FLG_SET:  if (clr && !hit) st_nxt = FLG_IDLE;
            default:                   st_nxt = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (st == FLG_SET);
    end
endmodule

// File: rtl/alarm_pair_matcher.sv
module alarm_pair_matcher
    import alarm_pkg::*;
#(
    parameter int N_ALM = 2,
    localparam int IDX_W = (N_ALM > 1) ? $clog2(N_ALM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [SEC_W-1:0]   cur_sec,
    input  logic [MIN_W-1:0]   cur_min,
    input  logic [HOUR_W-1:0]  cur_hour,
    input  logic [DAY_W-1:0]   cur_day,
    input  logic [MON_W-1:0]   cur_mon,
    input  logic [WDAY_W-1:0]  cur_wday,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FCODE_W-1:0] wr_field,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_match_en,
    input  logic [N_ALM-1:0]   irq_en,
    input  logic [N_ALM-1:0]   clr,
    output logic [N_ALM-1:0]   flag,
    output logic               irq_n
);
    cal_t             now_cal;
    logic [N_ALM-1:0] hit_vec;
    logic [N_ALM-1:0] flag_vec;

    assign now_cal.sec  = cur_sec;
    assign now_cal.min  = cur_min;
    assign now_cal.hour = cur_hour;
    assign now_cal.day  = cur_day;
    assign now_cal.mon  = cur_mon;
    assign now_cal.wday = cur_wday;

    // R8: each slot is a separate register set, matcher and flag machine
    for (genvar g = 0; g < N_ALM; g++) begin : g_alm
        cal_t                  alm_cal;
        logic [NUM_FIELDS-1:0] alm_fen;

        alarm_slot_regs #(.SLOT(g), .IDX_W(IDX_W)) u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_en),
            .wr_idx      (wr_idx),
            .wr_field    (wr_field),
            .wr_data     (wr_data),
            .wr_match_en (wr_match_en),
            .alm         (alm_cal),
            .fen         (alm_fen)
        );

        alarm_match u_match (
            .tick (tick),
            .now  (now_cal),
            .alm  (alm_cal),
            .fen  (alm_fen),
            .hit  (hit_vec[g])
        );

        alarm_flag_fsm u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_vec[g]),
            .clr   (clr[g]),
            .flag  (flag_vec[g])
        );
    end

    assign flag  = flag_vec;
    // R7: shared active-low line, each flag gated by its own enable
    assign irq_n = ~|(flag_vec & irq_en);
endmodule

// File: rtl/alarm_matcher_chk.sv
module alarm_matcher_chk #(
    parameter int N_ALM = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [N_ALM-1:0] clr,
    input logic [N_ALM-1:0] irq_en,
    input logic [N_ALM-1:0] hit,
    input logic [N_ALM-1:0] flag,
    input logic             irq_n
);
    p_hit_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> tick);

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> irq_n);

    for (genvar i = 0; i < N_ALM; i++) begin : g_chk
        p_hit_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flag[i]);

        p_no_tick_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && !flag[i]) |=> !flag[i]);

        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr[i]) |=> flag[i]);

        p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && clr[i] && !hit[i]) |=> !flag[i]);

        p_irq_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && irq_en[i]) |-> !irq_n);
    end
endmodule

bind alarm_pair_matcher alarm_matcher_chk #(.N_ALM(N_ALM)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (clr),
    .irq_en (irq_en),
    .hit    (hit_vec),
    .flag   (flag),
    .irq_n  (irq_n)
);

// File: tb/tb_alarm_pair_matcher.sv
`timescale 1ns/1ps
module tb_alarm_pair_matcher;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [5:0] cur_sec, cur_min;
    logic [4:0] cur_hour, cur_day;
    logic [3:0] cur_mon;
    logic [2:0] cur_wday;
    logic       wr_en = 1'b0;
    logic [0:0] wr_idx = '0;
    logic [2:0] wr_field = '0;
    logic [5:0] wr_data = '0;
    logic       wr_match_en = 1'b0;
    logic [1:0] irq_en = '0;
    logic [1:0] clr = '0;
    logic [1:0] flag;
    logic       irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    int now_v [6];
    int m_val [2][6];
    bit m_en  [2][6];
    bit m_flag[2];

    always #2.5 clk = ~clk;

    assign cur_sec  = now_v[0][5:0];
    assign cur_min  = now_v[1][5:0];
    assign cur_hour = now_v[2][4:0];
    assign cur_day  = now_v[3][4:0];
    assign cur_mon  = now_v[4][3:0];
    assign cur_wday = now_v[5][2:0];

    alarm_pair_matcher dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .cur_mon(cur_mon), .cur_wday(cur_wday),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_field(wr_field),
        .wr_data(wr_data), .wr_match_en(wr_match_en),
        .irq_en(irq_en), .clr(clr), .flag(flag), .irq_n(irq_n)
    );

    function automatic int fmask(int f);
        case (f)
            0, 1:    return 63;
            2, 3:    return 31;
            4:       return 15;
            default: return 7;
        endcase
    endfunction

    function automatic bit model_hit(int a);
        bit any = 0;
        bit all = 1;
        if (!tick) return 0;
        for (int f = 0; f < 6; f++) begin
            if (m_en[a][f]) begin
                any = 1;
                if (m_val[a][f] != now_v[f]) all = 0;
            end
        end
        return any && all;
    endfunction

    function automatic bit exp_irq_n();
        bit low = 0;
        for (int a = 0; a < 2; a++) if (m_flag[a] && irq_en[a]) low = 1;
        return !low;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // inputs already driven at a falling edge; model follows the rising edge
    task automatic cycle(string tag);
        bit h[2];
        @(posedge clk);
        for (int a = 0; a < 2; a++) h[a] = model_hit(a);
        if (wr_en && wr_field < 6) begin
            m_val[wr_idx][wr_field] = wr_data & fmask(wr_field);
            m_en[wr_idx][wr_field]  = wr_match_en;
        end
        for (int a = 0; a < 2; a++)
            m_flag[a] = h[a] ? 1'b1 : (clr[a] ? 1'b0 : m_flag[a]);
        @(negedge clk);
        for (int a = 0; a < 2; a++) chk($sformatf("%s flag%0d", tag, a), flag[a], m_flag[a]);
        chk($sformatf("%s irq_n", tag), irq_n, exp_irq_n());
        tick = 0; wr_en = 0; clr = '0;
    endtask

    task automatic wr(int a, int f, int d, bit en, string tag);
        wr_en = 1; wr_idx = a[0:0]; wr_field = f[2:0]; wr_data = d[5:0]; wr_match_en = en;
        cycle(tag);
    endtask

    task automatic set_time(int s, int mi, int h, int d, int mo, int w);
        now_v[0] = s; now_v[1] = mi; now_v[2] = h;
        now_v[3] = d; now_v[4] = mo; now_v[5] = w;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < 2; a++) begin
            m_flag[a] = 0;
            for (int f = 0; f < 6; f++) begin m_val[a][f] = 0; m_en[a][f] = 0; end
        end
        set_time(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 flag in reset", flag, 0);
        chk("R1 irq_n in reset", irq_n, 1);
        rst_n = 1;
        @(negedge clk);
        irq_en = 2'b11;
        tick = 1;
        cycle("R1 no enables after reset");   // all-zero time must not match

        // R2, R3: slot 0 on second 5, slot 1 left alone (R8)
        wr(0, 0, 5, 1, "R2 write sec");
        set_time(5, 9, 9, 9, 9, 1);
        tick = 1; cycle("R3 match sec only");
        chk("R8 slot1 untouched", flag[1], 0);

        // R7: masking the interrupt keeps the polled flag
        irq_en = 2'b00; cycle("R7 irq masked");
        chk("R7 flag still polled", flag[0], 1);
        irq_en = 2'b01; cycle("R7 irq routed");

        // R6: clear without match, then clear with match
        clr = 2'b01; cycle("R6 clear");
        tick = 1; clr = 2'b01; cycle("R6 match beats clear");
        clr = 2'b01; cycle("R6 clear again");

        // R4: matching time without tick
        cycle("R4 no tick");
        cycle("R4 no tick twice");

        // R5: disabled fields mismatch freely; disable every field
        wr(0, 1, 30, 0, "R5 minute value disabled");
        tick = 1; cycle("R5 disabled field ignored");
        clr = 2'b01; cycle("R6 clear");
        wr(0, 0, 5, 0, "R5 disable last field");
        tick = 1; cycle("R5 empty slot never fires");

        // R2: codes 6 and 7 ignored
        wr(1, 5, 1, 1, "R2 wday slot1");
        wr(1, 6, 2, 0, "R2 code6 ignored");
        wr(1, 7, 3, 0, "R2 code7 ignored");
        irq_en = 2'b10;
        tick = 1; cycle("R2 slot1 still wday 1");
        chk("R8 slot0 unaffected", flag[0], 0);
        clr = 2'b10; cycle("R6 clear slot1");

        // R9: write in tick cycle uses old contents
        set_time(5, 9, 9, 9, 9, 2);
        wr_en = 1; wr_idx = 1; wr_field = 5; wr_data = 2; wr_match_en = 1;
        tick = 1; cycle("R9 old value in write cycle");
        tick = 1; cycle("R9 new value next tick");
        clr = 2'b11; cycle("R6 clear both");

        // random mix, small value ranges so matches occur
        for (int i = 0; i < 3000; i++) begin
            set_time($urandom % 3, $urandom % 3, $urandom % 3,
                     $urandom % 3, $urandom % 3, $urandom % 3);
            tick = ($urandom % 2) != 0;
            clr = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'b00;
            if ($urandom % 8 == 0) irq_en = 2'($urandom % 4);
            if ($urandom % 3 == 0) begin
                wr_en = 1; wr_idx = 1'($urandom % 2); wr_field = 3'($urandom % 8);
                wr_data = 6'($urandom % 3); wr_match_en = ($urandom % 3) != 0;
            end
            cycle("R3 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule